// File: doc/BRIEF.md
# Fetch Address Region Remapper

This block sits on the instruction-fetch path in front of a cache. It holds four programmable remap regions, numbered 0 to 3. When a fetch address falls inside an enabled region, the block swaps the address's upper bits for a programmed target. It also reports which region matched, together with that region's route and burst attributes. Addresses that match no region go through unchanged.

Each region is one 32-bit register. Software writes a region through a simple select/write-enable port and can read the selected region back at any time. While the cache enable input is high, the region registers are frozen, so the mapping cannot change under live traffic. The region match and the address rewrite are computed combinationally, and the result is registered, so every input beat appears at the outputs exactly one clock later.

Region register layout: bits 7:0 hold the base (address bits 28:21), bits 10:8 hold the size code, bits 26:16 hold the target (address bits 31:21), bit 28 holds the route select, bit 29 holds the burst select and bit 31 holds the enable. All other bits are stored as zero.

Top module: `fetch_remap`

## Requirements
- R1: After reset, every region register reads 0, and `out_valid`, `out_hit`, `out_addr`, `out_region`, `out_route` and `out_burst` are all 0.
- R2: With `cache_en` low, a `cfg_we` pulse stores `cfg_wdata & 32'hB7FF07FF` into region `cfg_sel` at that clock edge. The stored value is visible on `cfg_rdata` whenever `cfg_sel` selects that region.
- R3: While `cache_en` is high, `cfg_we` has no effect on any region register.
- R4: A size code c in 1..7 selects a region of 2 MB << (c-1). An address matches when its bits 28:21 equal the base field on every bit except the lowest c-1 bits, which are ignored. Address bits 31:29 are never compared.
- R5: On a match, `out_addr[31:21]` takes the target field on its upper 12-c bits. Every address bit below the region boundary (the lowest 20+c bits) comes from the input address.
- R6: A region with its enable bit clear, or with size code 0, never matches.
- R7: When several regions match the same address, the lowest-numbered region is reported and used.
- R8: An address that matches no region gives `out_addr` equal to `in_addr` and `out_hit` = 0, with `out_region`, `out_route` and `out_burst` all 0.
- R9: `out_valid` equals `in_valid` from one cycle earlier. On a hit, `out_region`, `out_route` and `out_burst` give the matched region's index and its bits 28 and 29. When `out_valid` is 0, all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enabled; blocks region writes while high |
| cfg_we | input | 1 | Region register write strobe |
| cfg_sel | input | 2 | Region index for write and readback |
| cfg_wdata | input | 32 | Region register write value |
| cfg_rdata | output | 32 | Selected region register contents |
| in_valid | input | 1 | Fetch address valid |
| in_addr | input | 32 | Fetch address |
| out_valid | output | 1 | Translated address valid |
| out_addr | output | 32 | Translated address |
| out_hit | output | 1 | A region matched |
| out_region | output | 2 | Index of the matched region |
| out_route | output | 1 | Route select of the matched region |
| out_burst | output | 1 | Burst select of the matched region |

## Verification
A corrupted region register shows up on `cfg_rdata` as soon as that region is selected. On the translated path it shows up one cycle after the first fetch that falls into the affected address window. A fault in the size mask appears as a wrong hit or miss only near region edges, or as wrong target bits on the boundary bits. For that reason the stimulus places addresses just inside and just outside each region at every size code. A priority fault appears only when regions overlap, so overlapping regions are built on purpose and then removed one by one.

// File: rtl/fetch_remap.sv
module fetch_remap #(
  parameter int REGIONS = 4,
  parameter int IDX_W   = $clog2(REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              out_valid,
  output logic [31:0]       out_addr,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_region,
  output logic              out_route,
  output logic              out_burst
);
  localparam int          LSB    = 21;
  localparam int          BASE_W = 8;
  localparam int          TGT_W  = 32 - LSB;
  localparam int          TGT_LO = 16;
  localparam int          SZ_LO  = 8;
  localparam int          RT_BIT = 28;
  localparam int          BU_BIT = 29;
  localparam int          EN_BIT = 31;
  localparam logic [31:0] WMASK  = 32'hB7FF_07FF;

  logic [REGIONS-1:0][31:0]      regs;
  logic [REGIONS-1:0]            hit;
  logic [REGIONS-1:0][TGT_W-1:0] hi;
  logic                          any_hit;
  logic [IDX_W-1:0]              win;
  logic [31:0]                   xaddr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) regs <= '0;
    else if (cfg_we && !cache_en) regs[cfg_sel] <= cfg_wdata & WMASK;

  assign cfg_rdata = regs[cfg_sel];

  for (genvar g = 0; g < REGIONS; g++) begin : g_reg
    logic [2:0]        sz, sh;
    logic [BASE_W-1:0] bm;
    logic [TGT_W-1:0]  rm;
    assign sz = regs[g][SZ_LO +: 3];
    assign sh = sz - 3'd1;
    assign bm = {BASE_W{1'b1}} << sh;
    assign rm = {TGT_W{1'b1}} << sh;
    assign hit[g] = regs[g][EN_BIT] && (sz != 3'd0) &&
                    (((in_addr[28:LSB] ^ regs[g][BASE_W-1:0]) & bm) == '0);
    assign hi[g] = (regs[g][TGT_LO +: TGT_W] & rm) | (in_addr[31:LSB] & ~rm);
  end

  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    for (int i = REGIONS - 1; i >= 0; i--)
      if (hit[i]) begin
        any_hit = 1'b1;
        win     = IDX_W'(i);
      end
  end

  assign xaddr = any_hit ? {hi[win], in_addr[LSB-1:0]} : in_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_hit    <= 1'b0;
      out_region <= '0;
      out_route  <= 1'b0;
      out_burst  <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_addr   <= in_valid ? xaddr : '0;
      out_hit    <= in_valid && any_hit;
      out_region <= (in_valid && any_hit) ? win : '0;
      out_route  <= in_valid && any_hit && regs[win][RT_BIT];
      out_burst  <= in_valid && any_hit && regs[win][BU_BIT];
    end
endmodule

module fetch_remap_chk #(
  parameter int REGIONS = 4,
  parameter int IDX_W   = $clog2(REGIONS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cache_en,
  input logic                     in_valid,
  input logic [31:0]              in_addr,
  input logic                     out_valid,
  input logic [31:0]              out_addr,
  input logic                     out_hit,
  input logic [IDX_W-1:0]         out_region,
  input logic                     out_route,
  input logic                     out_burst,
  input logic [REGIONS-1:0][31:0] regs
);
  a_r3_frozen_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    cache_en |=> regs == $past(regs));
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_hit && out_addr == '0 && out_region == '0 && !out_route && !out_burst);
  a_r8_miss_attrs: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_region == '0 && !out_route && !out_burst);
  a_r8_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_hit || out_addr == $past(in_addr));
  a_r5_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr[20:0] == $past(in_addr[20:0]));
endmodule

bind fetch_remap fetch_remap_chk #(.REGIONS(REGIONS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .in_valid(in_valid),
  .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
  .out_hit(out_hit), .out_region(out_region), .out_route(out_route),
  .out_burst(out_burst), .regs(regs));

// File: tb/fetch_remap_test.sv
module fetch_remap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b0, cfg_we = 1'b0, in_valid = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0, in_addr = '0;
  logic [31:0] cfg_rdata, out_addr;
  logic        out_valid, out_hit, out_route, out_burst;
  logic [1:0]  out_region;

  int errors = 0, checks = 0;
  logic [31:0] mreg [4];

  bit          e_valid, e_hit, e_route, e_burst;
  logic [31:0] e_addr;
  int          e_idx;
  string       e_tag = "R1";

  always #10 clk = ~clk;

  fetch_remap uut (.clk(clk), .rst_n(rst_n), .cache_en(cache_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_hit(out_hit), .out_region(out_region),
    .out_route(out_route), .out_burst(out_burst));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, output bit h, output int idx,
                                output logic [31:0] o, output bit rt, output bit bu);
    h = 0; idx = 0; o = a; rt = 0; bu = 0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] r, size, start;
      int code;
      r = mreg[i];
      code = int'(r[10:8]);
      if (!h && r[31] && code != 0) begin
        size  = 32'h0020_0000 << (code - 1);
        start = {3'b000, r[7:0], 21'd0} & ~(size - 1);
        if (((a & 32'h1FFF_FFFF) & ~(size - 1)) == start) begin
          h = 1; idx = i; rt = r[28]; bu = r[29];
          o = ({r[26:16], 21'd0} & ~(size - 1)) | (a & (size - 1));
        end
      end
    end
  endfunction

  task automatic step(input bit we, input int sel, input logic [31:0] wd, input bit cen,
                      input bit iv, input logic [31:0] a, input string tag = "");
    bit h, rt, bu; int idx; logic [31:0] o;
    @(negedge clk);
    chk(e_tag, "out_valid", 32'(out_valid), 32'(e_valid));
    chk(e_tag, "out_addr", out_addr, e_addr);
    chk(e_tag, "out_hit", 32'(out_hit), 32'(e_hit));
    chk(e_tag, "out_region", 32'(out_region), 32'(e_idx));
    chk(e_tag, "out_route", 32'(out_route), 32'(e_route));
    chk(e_tag, "out_burst", 32'(out_burst), 32'(e_burst));
    cfg_we = we; cfg_sel = 2'(sel); cfg_wdata = wd; cache_en = cen;
    in_valid = iv; in_addr = a;
    #1;
    chk(cen ? "R3" : "R2", "cfg_rdata", cfg_rdata, mreg[sel]);
    model(a, h, idx, o, rt, bu);
    e_valid = iv;
    e_hit   = iv && h;
    e_addr  = iv ? o : 32'd0;
    e_idx   = (iv && h) ? idx : 0;
    e_route = iv && rt;
    e_burst = iv && bu;
    e_tag   = (tag != "") ? tag : (!iv ? "R9" : (h ? "R5" : "R8"));
    if (we && !cen) mreg[sel] = wd & 32'hB7FF_07FF;
  endtask

  function automatic logic [31:0] cfgv(bit en, bit bu, bit rt, logic [10:0] tgt,
                                       logic [2:0] sz, logic [7:0] base);
    return {en, 1'b0, bu, rt, 1'b0, tgt, 5'd0, sz, base};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    e_valid = 0; e_hit = 0; e_route = 0; e_burst = 0; e_addr = '0; e_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state on all outputs and every register
    for (int i = 0; i < 4; i++) step(0, i, 0, 0, 0, 0, "R1");

    // R2: program region 0, 2 MB at 0x0200_0000 -> 0x8000_0000, route set
    step(1, 0, cfgv(1, 0, 1, 11'h400, 3'd1, 8'h10) | 32'h4800_F800, 0, 0, 0);
    step(0, 0, 0, 0, 1, 32'h0200_1234, "R5");
    step(0, 0, 0, 0, 1, 32'h0220_0000, "R8");
    step(0, 0, 0, 0, 1, 32'h01FF_FFFF, "R8");
    step(0, 0, 0, 0, 1, 32'hE200_0010, "R4");
    step(0, 0, 0, 0, 0, 32'h0200_0000, "R9");

    // R4: 128 MB region with junk in ignored base/target bits
    step(1, 1, cfgv(1, 1, 0, 11'h123, 3'd7, 8'h5A), 0, 0, 0);
    step(0, 1, 0, 0, 1, 32'h0BFF_FFFC, "R4");
    step(0, 1, 0, 0, 1, 32'h0800_0000, "R4");
    step(0, 1, 0, 0, 1, 32'h07FF_FFFF, "R4");
    step(0, 1, 0, 0, 1, 32'h1000_0000, "R4");

    // R7: region 2 (4 MB) overlaps region 0
    step(1, 2, cfgv(1, 1, 1, 11'h7FF, 3'd2, 8'h11), 0, 0, 0);
    step(0, 2, 0, 0, 1, 32'h0210_0000, "R7");
    step(0, 2, 0, 0, 1, 32'h0230_0000, "R7");
    step(1, 0, 0, 0, 1, 32'h0210_0000, "R7");
    step(0, 0, 0, 0, 1, 32'h0210_0000, "R7");

    // R3: writes blocked while cache is enabled
    step(1, 3, cfgv(1, 0, 1, 11'h001, 3'd3, 8'h00), 1, 1, 32'h0000_0100, "R3");
    step(1, 2, 32'h0, 1, 1, 32'h0210_0000, "R3");
    step(0, 3, 0, 1, 1, 32'h0000_0100, "R3");
    step(0, 2, 0, 1, 1, 32'h0210_0000, "R3");

    // R6: size code 0 and disabled region never match
    step(1, 3, cfgv(1, 0, 1, 11'h001, 3'd0, 8'h00), 0, 0, 0);
    step(0, 3, 0, 0, 1, 32'h0000_0100, "R6");
    step(1, 3, cfgv(0, 0, 1, 11'h001, 3'd3, 8'h00), 0, 1, 32'h0000_0100, "R6");
    step(0, 3, 0, 0, 1, 32'h0000_0100, "R6");

    // R2/R4/R5/R8: every size code at edges, then random traffic
    for (int c = 1; c < 8; c++) begin
      logic [31:0] sz;
      sz = 32'h0020_0000 << (c - 1);
      step(1, 3, cfgv(1, c[0], c[1], 11'h555, 3'(c), 8'hA5), 0, 0, 0);
      step(0, 3, 0, 0, 1, ({3'b000, 8'hA5, 21'd0} & ~(sz - 1)), "R4");
      step(0, 3, 0, 0, 1, ({3'b000, 8'hA5, 21'd0} & ~(sz - 1)) + sz - 1, "R5");
      step(0, 3, 0, 0, 1, ({3'b000, 8'hA5, 21'd0} & ~(sz - 1)) + sz, "R4");
      step(0, 3, 0, 0, 1, ({3'b000, 8'hA5, 21'd0} & ~(sz - 1)) - 1, "R4");
    end
    for (int n = 0; n < 2000; n++) begin
      bit we, cen, iv; int sel; logic [31:0] wd, a, r;
      we  = ($urandom % 6) == 0;
      cen = ($urandom % 4) == 0;
      iv  = ($urandom % 5) != 0;
      sel = $urandom % 4;
      wd  = $urandom;
      if ($urandom % 3 != 0) wd[31] = 1'b1;
      r = mreg[$urandom % 4];
      a = $urandom;
      if ($urandom % 4 != 0) a[28:21] = r[7:0] ^ 8'(($urandom % 2) << ($urandom % 8));
      step(we, sel, wd, cen, iv, a);
    end
    step(0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule